// File: doc/BRIEF.md
# DMA Channel Staging Buffer Sequencer

This block sequences one channel of a two-cycle DMA transfer. A small per-channel staging buffer of four bytes sits between a request-paced device (the requester) and a memory or I/O target. The sequencer fetches units into the buffer with bus read cycles and empties it with bus write cycles. It sizes every cycle from the bus width of the side being accessed. It counts down the programmed byte total and flags terminal count once the total is spent. Address generation and arbitration live elsewhere. This block only decides which cycle comes next, on which side, at which size and with which data.

The direction select changes the pacing. In read direction (`dir_wr`=0) data flows from requester to target. Each request pulse brings in one unit, and a full buffer drains to the target as an unbroken burst. In write direction (`dir_wr`=1) data flows from target to requester. One request pulse triggers a burst of reads that fills the buffer, and one write to the requester follows at once. Every later request pulse releases one more write.

Top module: `dma_stage_seq`

## Requirements
- R1: After reset, `busy`, `bus_req` and `tc` are all 0.
- R2: `start` sampled high while idle, with a nonzero `count_in`, latches the count, direction and both widths and makes `busy` 1. No bus cycle begins until `dreq` is seen. A `start` with `count_in` of zero is ignored, and `busy` stays 0.
- R3: A bus cycle (`bus_req`=1) completes only on a rising edge where `ready_n` is 0. Until then `bus_req`, `bus_write`, `bus_to_req` and `bus_wide` hold their values.
- R4: In read direction each accepted `dreq` yields exactly one read cycle from the requester (`bus_write`=0, `bus_to_req`=1). The sequencer then waits for the next `dreq` unless the fill is complete.
- R5: A fill ends once the buffer holds min(4, remaining count) bytes. In read direction the writes to the target (`bus_write`=1, `bus_to_req`=0) then follow back to back with no `dreq` until the buffer is empty.
- R6: In write direction one accepted `dreq` starts back-to-back reads from the target (`bus_to_req`=0) until the fill ends.
- R7: In write direction the first write to the requester (`bus_to_req`=1) starts in the cycle right after the fill completes. Each further write waits for its own `dreq`.
- R8: A cycle is a word (`bus_wide`=1) when the side it accesses is 16 bits wide and at least 2 bytes remain: still to fetch for a read, still buffered for a write. Otherwise it is a byte.
- R9: Bytes leave the buffer in arrival order. A read stores `bus_rdata[7:0]` first and, for a word, `bus_rdata[15:8]` next. A word write drives the older byte on `bus_wdata[7:0]`. A byte write drives its byte on `bus_wdata[7:0]` with `bus_wdata[15:8]`=0.
- R10: Each completed write lowers the remaining count by 1 (byte) or 2 (word). When it reaches zero, `tc` is 1 for exactly the one cycle after the final write completes, with `busy` already 0.
- R11: `dreq` is ignored while a bus cycle or burst is in progress. It has an effect only while the sequencer is waiting with no cycle open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the present configuration |
| dir_wr | input | 1 | 0: requester to target, 1: target to requester |
| req_wide | input | 1 | Requester bus is 16 bits |
| tgt_wide | input | 1 | Target bus is 16 bits |
| count_in | input | CNT_W | Bytes to move |
| dreq | input | 1 | Service request from the requester |
| ready_n | input | 1 | Active-low cycle completion |
| bus_rdata | input | 16 | Read data for the open read cycle |
| bus_req | output | 1 | A bus cycle is open |
| bus_write | output | 1 | Open cycle is a write |
| bus_to_req | output | 1 | Open cycle addresses the requester (else the target) |
| bus_wide | output | 1 | Open cycle moves a word |
| bus_wdata | output | 16 | Write data for the open write cycle |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal count pulse |

## Verification
The bench targets odd byte counts on wide buses. There the last unit must fall back to a byte, and a design that keeps issuing words would overrun the count and corrupt the final byte. Mixed widths, such as byte fills drained as words, expose a wrong byte order on `bus_wdata`. Counts below four check that the fill stops early instead of waiting for a `dreq` that never comes. The bench counts the `dreq` pulses each transfer consumes against the pacing model and drives `dreq` high at random during open cycles. A design that lets the burst in read direction wait for requests, or that issues the first write in write direction only after a request, shows a wrong pulse count. So does a design that reacts to `dreq` mid-burst.

// File: rtl/dma_stage_pkg.sv
package dma_stage_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_state_t;

  // bytes one fill aims for: the buffer capacity, or fewer near the end
  function automatic int fill_goal(input int left, input int cap);
    return (left >= cap) ? cap : left;
  endfunction

  // size of one bus cycle: a word only when the side is wide and 2+ bytes remain
  function automatic int unit_bytes(input logic wide, input int room);
    return (wide && room >= 2) ? 2 : 1;
  endfunction

endpackage

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int BYTES = 4,
  parameter int PW    = $clog2(BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          wr_two,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  input  logic          rd_two,
  output logic [PW-1:0] fill_lvl,
  output logic [PW-1:0] rd_pos,
  output logic [15:0]   rd_data
);
  localparam int AW = $clog2(BYTES);

  logic [7:0]    slot [BYTES];
  logic [PW-1:0] fill_nxt;
  logic [PW-1:0] rd_nxt;

  assign fill_nxt = fill_lvl + PW'(1);
  assign rd_nxt   = rd_pos + PW'(1);

  for (genvar i = 0; i < BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot[i] <= 8'h00;
      else if (wr_en && fill_lvl == PW'(i))         slot[i] <= wr_data[7:0];
      else if (wr_en && wr_two && fill_nxt == PW'(i)) slot[i] <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_lvl <= '0;
      rd_pos   <= '0;
    end else if (clr) begin
      fill_lvl <= '0;
      rd_pos   <= '0;
    end else begin
      if (wr_en) fill_lvl <= fill_lvl + (wr_two ? PW'(2) : PW'(1));
      if (rd_en) rd_pos   <= rd_pos + (rd_two ? PW'(2) : PW'(1));
    end
  end

  assign rd_data = {rd_two ? slot[rd_nxt[AW-1:0]] : 8'h00, slot[rd_pos[AW-1:0]]};

  // R5: a fill never writes past the buffer capacity
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(fill_lvl) + (wr_two ? 2 : 1) <= BYTES));

  // R9: data is only read from positions already filled
  a_r9_read_behind_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_pos) + (rd_two ? 2 : 1) <= int'(fill_lvl)));

endmodule

// File: rtl/dma_stage_cnt.sv
module dma_stage_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  input  logic             dec_two,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (dec_en) cnt <= cnt - (dec_two ? CNT_W'(2) : CNT_W'(1));
  end

  // R10: the count is never decremented below zero
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (cnt >= (dec_two ? CNT_W'(2) : CNT_W'(1))));

endmodule

// File: rtl/dma_stage_seq.sv
module dma_stage_seq
  import dma_stage_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic             req_wide,
  input  logic             tgt_wide,
  input  logic [CNT_W-1:0] count_in,
  input  logic             dreq,
  input  logic             ready_n,
  input  logic [15:0]      bus_rdata,
  output logic             bus_req,
  output logic             bus_write,
  output logic             bus_to_req,
  output logic             bus_wide,
  output logic [15:0]      bus_wdata,
  output logic             busy,
  output logic             tc
);
  localparam int PW = $clog2(BUF_BYTES) + 1;

  seq_state_t state_q, state_d;
  logic dir_q, rw_q, tw_q, drain_q, tc_q;

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    fill_lvl, rd_pos, goal, rd_sz, wr_sz;
  logic [15:0]      buf_rdata;
  logic             rd_wide, wr_wide;

  // named internal events
  logic load_ev, rd_done_ev, wr_done_ev, fill_done_ev, last_wr_ev, empty_ev;

  assign rd_wide = dir_q ? tw_q : rw_q;
  assign wr_wide = dir_q ? rw_q : tw_q;
  assign goal    = PW'(fill_goal(int'(cnt), BUF_BYTES));
  assign rd_sz   = PW'(unit_bytes(rd_wide, int'(goal - fill_lvl)));
  assign wr_sz   = PW'(unit_bytes(wr_wide, int'(fill_lvl - rd_pos)));

  assign load_ev      = (state_q == ST_IDLE) && start && (count_in != '0);
  assign rd_done_ev   = (state_q == ST_RD) && !ready_n;
  assign wr_done_ev   = (state_q == ST_WR) && !ready_n;
  assign fill_done_ev = rd_done_ev && ((fill_lvl + rd_sz) == goal);
  assign last_wr_ev   = wr_done_ev && (cnt == CNT_W'(wr_sz));
  assign empty_ev     = wr_done_ev && ((rd_pos + wr_sz) == fill_lvl);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_ev) state_d = ST_WAIT;
      ST_WAIT: if (dreq) state_d = drain_q ? ST_WR : ST_RD;
      ST_RD: if (rd_done_ev) begin
        if (fill_done_ev) state_d = ST_WR;
        else              state_d = dir_q ? ST_RD : ST_WAIT;
      end
      ST_WR: if (wr_done_ev) begin
        if (last_wr_ev)    state_d = ST_IDLE;
        else if (empty_ev) state_d = ST_WAIT;
        else               state_d = dir_q ? ST_WAIT : ST_WR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      rw_q    <= 1'b0;
      tw_q    <= 1'b0;
      drain_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tc_q    <= last_wr_ev;
      if (load_ev) begin
        dir_q   <= dir_wr;
        rw_q    <= req_wide;
        tw_q    <= tgt_wide;
        drain_q <= 1'b0;
      end else if (fill_done_ev) begin
        drain_q <= 1'b1;
      end else if (empty_ev) begin
        drain_q <= 1'b0;
      end
    end
  end

  dma_stage_buf #(.BYTES(BUF_BYTES), .PW(PW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load_ev | empty_ev | last_wr_ev),
    .wr_en    (rd_done_ev),
    .wr_two   (rd_sz == PW'(2)),
    .wr_data  (bus_rdata),
    .rd_en    (wr_done_ev),
    .rd_two   (wr_sz == PW'(2)),
    .fill_lvl (fill_lvl),
    .rd_pos   (rd_pos),
    .rd_data  (buf_rdata)
  );

  dma_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .load_val (count_in),
    .dec_en   (wr_done_ev),
    .dec_two  (wr_sz == PW'(2)),
    .cnt      (cnt)
  );

  assign bus_req    = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_write  = (state_q == ST_WR);
  assign bus_to_req = (state_q == ST_RD) ^ dir_q;
  assign bus_wide   = (state_q == ST_RD) ? (rd_sz == PW'(2)) : (wr_sz == PW'(2));
  assign bus_wdata  = buf_rdata;
  assign busy       = (state_q != ST_IDLE);
  assign tc         = tc_q;

  // R3: an open cycle holds its attributes through wait states
  a_r3_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && ready_n) |=> (bus_req && $stable(bus_write) && $stable(bus_to_req) && $stable(bus_wide)));

  // R4: in read direction an unfinished fill returns to waiting after each read
  a_r4_one_read_per_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && rd_done_ev && !fill_done_ev) |=> !bus_req);

  // R5: in read direction the drain starts with no gap
  a_r5_drain_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && fill_done_ev) |=> (bus_req && bus_write && !bus_to_req));

  // R7: in write direction the first write follows the fill at once
  a_r7_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && fill_done_ev) |=> (bus_req && bus_write && bus_to_req));

  // R10: terminal count is a single pulse seen only when idle
  a_r10_tc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> !busy);
  a_r10_tc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

endmodule

// File: tb/dma_stage_seq_bench.sv
`timescale 1ns/1ps
module dma_stage_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_wr = 1'b0;
  logic        req_wide = 1'b0;
  logic        tgt_wide = 1'b0;
  logic [15:0] count_in = '0;
  logic        dreq = 1'b0;
  logic        ready_n = 1'b1;
  logic [15:0] bus_rdata = '0;
  logic        bus_req, bus_write, bus_to_req, bus_wide, busy, tc;
  logic [15:0] bus_wdata;

  always #4 clk = ~clk;

  dma_stage_seq u_dma_stage_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .req_wide(req_wide), .tgt_wide(tgt_wide), .count_in(count_in),
    .dreq(dreq), .ready_n(ready_n), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_to_req(bus_to_req),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .busy(busy), .tc(tc)
  );

  int total = 0;
  int bad = 0;

  // expected cycle plan
  bit p_wr [256];
  bit p_to [256];
  bit p_wd [256];
  int pn, pulses_exp;
  // bytes read but not yet written
  logic [7:0] dq [1024];
  int dh, dt;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sz(input bit wide, input int room);
    if (wide && room > 1) return 2;
    return 1;
  endfunction

  // build expected cycles and dreq pulses from the requirements
  task automatic build_plan(input bit d, input bit rw, input bit tw, input int n);
    int rem = n;
    pn = 0; pulses_exp = 0;
    while (rem > 0) begin
      int chunk = (rem < 4) ? rem : 4;
      int got = 0;
      int put = 0;
      bit first = 1'b1;
      while (got < chunk) begin                 // R4 R6 R8
        int s = sz(d ? tw : rw, chunk - got);
        p_wr[pn] = 0; p_to[pn] = !d; p_wd[pn] = (s == 2); pn++;
        if (!d || first) pulses_exp++;
        first = 1'b0;
        got += s;
      end
      first = 1'b1;
      while (put < chunk) begin                 // R5 R7 R8
        int s = sz(d ? rw : tw, chunk - put);
        p_wr[pn] = 1; p_to[pn] = d; p_wd[pn] = (s == 2); pn++;
        if (d && !first) pulses_exp++;
        first = 1'b0;
        put += s;
      end
      rem -= chunk;
    end
  endtask

  task automatic run_xfer(input bit d, input bit rw, input bit tw, input int n);
    int idx = 0;
    int pulses = 0;
    int guard = 0;
    bit held = 1'b0;
    bit done = 1'b0;
    bit h_wr, h_to, h_wd;
    build_plan(d, rw, tw, n);
    dh = 0; dt = 0;
    @(negedge clk);
    dir_wr = d; req_wide = rw; tgt_wide = tw; count_in = 16'(n);
    start = 1'b1; dreq = 1'b0; ready_n = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    while (!done) begin
      guard++;
      if (guard > 4000) begin
        chk(1'b0, "R10", "watchdog: transfer never finished", idx, pn);
        done = 1'b1;
      end else if (tc === 1'b1) begin
        chk(idx == pn, "R10", "cycles before tc", idx, pn);
        chk(busy === 1'b0, "R10", "busy with tc", int'(busy), 0);
        chk(pulses == pulses_exp, "R11", "dreq pulses consumed", pulses, pulses_exp);
        dreq = 1'b0; ready_n = 1'b1;
        @(negedge clk);
        chk(tc === 1'b0, "R10", "tc pulse width", int'(tc), 0);
        done = 1'b1;
      end else if (busy !== 1'b1) begin
        chk(1'b0, "R10", "idle without tc", idx, pn);
        done = 1'b1;
      end else if (bus_req === 1'b1) begin
        if (held) begin
          chk(bus_write == h_wr && bus_to_req == h_to && bus_wide == h_wd, "R3",
              "cycle changed during wait state", int'({bus_write, bus_to_req, bus_wide}),
              int'({h_wr, h_to, h_wd}));
        end
        dreq = 1'($urandom_range(0, 1));       // R11 noise, must be ignored
        ready_n = ($urandom_range(0, 2) == 0);
        held = ready_n; h_wr = bus_write; h_to = bus_to_req; h_wd = bus_wide;
        if (!ready_n) begin
          if (idx >= pn) begin
            chk(1'b0, "R10", "extra bus cycle", idx, pn);
          end else begin
            chk(bus_write == p_wr[idx] && bus_to_req == p_to[idx] && bus_wide == p_wd[idx],
                "R8", "cycle kind {write,to_req,wide}",
                int'({bus_write, bus_to_req, bus_wide}), int'({p_wr[idx], p_to[idx], p_wd[idx]}));
            if (!bus_write) begin
              bus_rdata = 16'($urandom);
              dq[dt] = bus_rdata[7:0]; dt++;
              if (bus_wide) begin dq[dt] = bus_rdata[15:8]; dt++; end
            end else begin
              logic [15:0] e;
              e = bus_wide ? {dq[dh+1], dq[dh]} : {8'h00, dq[dh]};
              chk(bus_wdata == e, "R9", "write data", int'(bus_wdata), int'(e));
              dh += bus_wide ? 2 : 1;
            end
            idx++;
          end
        end
      end else begin
        held = 1'b0;
        ready_n = 1'b1;
        dreq = ($urandom_range(0, 3) != 0);
        if (dreq) pulses++;
      end
      if (!done) @(negedge clk);
    end
    dreq = 1'b0; ready_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && bus_req === 1'b0 && tc === 1'b0, "R1", "reset outputs",
        int'({busy, bus_req, tc}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero count is ignored
    count_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, "R2", "zero count start", int'(busy), 0);

    // R2: nonzero start waits quietly for dreq
    count_in = 16'd2; dir_wr = 1'b0; req_wide = 1'b0; tgt_wide = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_req === 1'b0, "R2", "no cycle without dreq", int'(bus_req), 0);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    chk(bus_req === 1'b1 && bus_to_req === 1'b1, "R4", "read from requester after dreq",
        int'({bus_req, bus_to_req}), 3);
    ready_n = 1'b0; bus_rdata = 16'h00a5;
    @(negedge clk);
    ready_n = 1'b1;
    chk(bus_req === 1'b0, "R4", "waits for next dreq", int'(bus_req), 0);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0; ready_n = 1'b0; bus_rdata = 16'h003c;
    @(negedge clk);
    ready_n = 1'b1;
    chk(bus_req && bus_write && !bus_to_req && bus_wdata == 16'h00a5, "R5",
        "drain starts at once with first byte", int'(bus_wdata), 16'h00a5);
    ready_n = 1'b0;
    @(negedge clk);
    chk(bus_write && bus_wdata == 16'h003c, "R9", "second byte", int'(bus_wdata), 16'h003c);
    @(negedge clk);
    ready_n = 1'b1;
    chk(tc === 1'b1 && busy === 1'b0, "R10", "tc after final write", int'({tc, busy}), 2);
    @(negedge clk);

    // directed corners
    run_xfer(1'b0, 1'b0, 1'b0, 4);
    run_xfer(1'b1, 1'b1, 1'b1, 7);
    run_xfer(1'b0, 1'b1, 1'b0, 5);
    run_xfer(1'b1, 1'b0, 1'b1, 1);
    run_xfer(1'b0, 1'b0, 1'b1, 3);
    run_xfer(1'b1, 1'b1, 1'b0, 9);
    // random mix
    for (int k = 0; k < 30; k++) begin
      run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), int'($urandom_range(1, 40)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule